// File: doc/BRIEF.md
# Open-Page Controller for Asynchronous Multiplexed-Address DRAM

This block sits between a synchronous host and an asynchronous DRAM device whose row and column addresses share one set of pins. The host hands over a single read or write through a valid/ready handshake. The controller splits the host address into a row part and a column part. It presents the row on the shared pins and then lowers the row strobe. It presents the column and then lowers the column strobe. A one-cycle response pulse reports that the access has finished. For reads, the pulse comes with the captured data.

After an access the row stays open, with the row strobe held low. A later request to the same row costs only a column cycle. A request to another row first raises the row strobe, waits out the precharge time and then activates the new row. Writes are early writes: write-enable and the data drivers switch on before the column strobe falls. Reads enable the device output only while the column strobe is low. When a request changes direction on an open row, one extra idle column cycle is added. A refresh scheduler can ask for the pins. The controller then closes the open row and grants the pins with every strobe inactive. All timings are parameters counted in clock cycles.

Top module: `page_dram_ctrl`

## Requirements
- R1: Before the row strobe falls, the row address is held on the address pins for at least one cycle, and it does not change in the cycle where the strobe falls.
- R2: Before the column strobe falls, the column address is held on the address pins for at least one cycle. The column strobe is low only while the row strobe is low.
- R3: A request to the open row is served without raising the row strobe. Its latency from the accepting edge to the response pulse is T_CAS+1 cycles when the direction matches the previous access.
- R4: A request accepted with no row open gives a response after T_RCD+T_CAS+2 cycles. The row strobe stays low for T_RCD cycles before the column cycle.
- R5: A request to a different row than the open one raises the row strobe for T_RP cycles and then activates the new row. Its latency is T_RP+T_RCD+T_CAS+2 cycles, and a read returns the contents of the new row.
- R6: During a write, write-enable is low and the data drivers are on, both from at least one cycle before the column strobe falls. The column strobe stays low for T_CAS cycles. The data drivers are off outside write column cycles.
- R7: During a read, output-enable is low only while the column strobe is low. Read data is captured in the last cycle of that window. The response is a single-cycle pulse for every access, read or write.
- R8: On an open-row request whose direction differs from the previous access, the latency grows by one cycle. Output-enable and the data drivers are never active together. At least one cycle separates output-enable going high from the data drivers turning on.
- R9: A refresh request closes any open row through a T_RP-cycle precharge and then raises the grant, with row and column strobes high. While the grant is high, ready stays low. The first access after the grant drops is a closed-row access.
- R10: During and right after reset, all four strobes are high (inactive), the data drivers are off, and the response and grant are low.
- R11: The row is the upper ROW_W bits of the host address and the column is the lower COL_W bits. Each is placed zero-extended on the address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Host word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_valid for reads |
| refresh_req | input | 1 | Refresh scheduler asks for the pins |
| refresh_grant | output | 1 | Pins handed over, strobes inactive |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq_out | output | DW | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DW | Data from the device |

## Verification
The assertions assume that the device answers within the CAS window. They also assume that refresh_req and the host request change only between clock edges, and that reset is held for at least one edge. The bench keeps to this. A behavioural device model drives read data combinationally whenever output-enable is low, using the row and column it latched at the strobe edges. All stimulus changes on the falling clock edge, and a refresh request is raised only while no host request is pending.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_CAS_HOLD,
    ST_PAGE_OPEN,
    ST_PRECHARGE
  } pdc_state_e;
endpackage

// File: rtl/pdc_addr_split.sv
`timescale 1ns/1ps
module pdc_addr_split #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int PIN_W = 8
) (
  input  logic [ROW_W+COL_W-1:0] host_addr,
  input  logic [ROW_W-1:0]       open_row,
  output logic [ROW_W-1:0]       row,
  output logic [PIN_W-1:0]       row_pins,
  output logic [PIN_W-1:0]       col_pins,
  output logic                   same_row
);
  localparam int AW = ROW_W + COL_W;

  assign row      = host_addr[AW-1 -: ROW_W];
  assign row_pins = PIN_W'(row);
  assign col_pins = PIN_W'(host_addr[COL_W-1:0]);
  assign same_row = (row == open_row);
endmodule

// File: rtl/pdc_dq_path.sv
`timescale 1ns/1ps
module pdc_dq_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drive_nxt,
  input  logic [DW-1:0] wdata_nxt,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      rdata  <= '0;
    end else begin
      dq_oe <= drive_nxt;
      if (drive_nxt) dq_out <= wdata_nxt;
      if (capture)   rdata  <= dq_in;
    end
  end

  // R7: read data register only moves on a capture
  a_r7_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rdata));
endmodule

// File: rtl/page_dram_ctrl.sv
`timescale 1ns/1ps
module page_dram_ctrl #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int DW    = 8,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2,
  localparam int AW    = ROW_W + COL_W,
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             refresh_req,
  output logic             refresh_grant,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_oe_n,
  output logic [PIN_W-1:0] dram_addr,
  output logic [DW-1:0]    dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [DW-1:0]    dram_dq_in
);
  import pdc_pkg::*;

  localparam int MAXT_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int MAXT   = (MAXT_A > T_RP) ? MAXT_A : T_RP;
  localparam int CNT_W  = (MAXT < 2) ? 1 : $clog2(MAXT + 1);

  pdc_state_e st, nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic pend, nxt_pend;
  logic take, done, accept;
  logic last_we;
  logic lat_we;
  logic [DW-1:0]    lat_wdata;
  logic [PIN_W-1:0] lat_row_pins, lat_col_pins;
  logic [ROW_W-1:0] open_row;

  logic [ROW_W-1:0] sp_row;
  logic [PIN_W-1:0] sp_row_pins, sp_col_pins;
  logic             sp_hit;

  pdc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_split (
    .host_addr (req_addr),
    .open_row  (open_row),
    .row       (sp_row),
    .row_pins  (sp_row_pins),
    .col_pins  (sp_col_pins),
    .same_row  (sp_hit)
  );

  assign accept = req_valid && req_ready;

  always_comb begin
    nxt      = st;
    nxt_cnt  = (cnt != '0) ? cnt - 1'b1 : cnt;
    nxt_pend = pend;
    take     = 1'b0;
    done     = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        take    = 1'b1;
        nxt     = ST_ACT;
        nxt_cnt = CNT_W'(T_RCD);
      end
      ST_ACT: if (cnt == '0) begin
        nxt     = ST_COL;
        nxt_cnt = '0;
      end
      ST_COL: if (cnt == '0) begin
        nxt     = ST_CAS_HOLD;
        nxt_cnt = CNT_W'(T_CAS - 1);
      end
      ST_CAS_HOLD: if (cnt == '0) begin
        nxt  = ST_PAGE_OPEN;
        done = 1'b1;
      end
      ST_PAGE_OPEN: begin
        if (accept) begin
          take = 1'b1;
          if (sp_hit) begin
            nxt     = ST_COL;
            nxt_cnt = (req_we != last_we) ? CNT_W'(1) : '0;
          end else begin
            nxt      = ST_PRECHARGE;
            nxt_cnt  = CNT_W'(T_RP - 1);
            nxt_pend = 1'b1;
          end
        end else if (refresh_req) begin
          nxt     = ST_PRECHARGE;
          nxt_cnt = CNT_W'(T_RP - 1);
        end
      end
      ST_PRECHARGE: if (cnt == '0) begin
        if (pend) begin
          nxt      = ST_ACT;
          nxt_cnt  = CNT_W'(T_RCD);
          nxt_pend = 1'b0;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  logic             we_eff, col_active, drive_nxt;
  logic [DW-1:0]    wdata_eff;
  logic [PIN_W-1:0] row_eff, col_eff;

  assign we_eff     = take ? req_we      : lat_we;
  assign wdata_eff  = take ? req_wdata   : lat_wdata;
  assign row_eff    = take ? sp_row_pins : lat_row_pins;
  assign col_eff    = take ? sp_col_pins : lat_col_pins;
  assign col_active = (nxt == ST_CAS_HOLD) || (nxt == ST_COL && nxt_cnt == '0);
  assign drive_nxt  = col_active && we_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cnt           <= '0;
      pend          <= 1'b0;
      last_we       <= 1'b0;
      lat_we        <= 1'b0;
      lat_wdata     <= '0;
      lat_row_pins  <= '0;
      lat_col_pins  <= '0;
      open_row      <= '0;
      req_ready     <= 1'b0;
      rsp_valid     <= 1'b0;
      refresh_grant <= 1'b0;
      dram_ras_n    <= 1'b1;
      dram_cas_n    <= 1'b1;
      dram_we_n     <= 1'b1;
      dram_oe_n     <= 1'b1;
      dram_addr     <= '0;
    end else begin
      st   <= nxt;
      cnt  <= nxt_cnt;
      pend <= nxt_pend;
      if (take) begin
        lat_we       <= req_we;
        lat_wdata    <= req_wdata;
        lat_row_pins <= sp_row_pins;
        lat_col_pins <= sp_col_pins;
        open_row     <= sp_row;
      end
      if (done) last_we <= lat_we;
      req_ready     <= (nxt == ST_IDLE || nxt == ST_PAGE_OPEN) && !refresh_req;
      rsp_valid     <= done;
      refresh_grant <= (nxt == ST_IDLE) && refresh_req;
      dram_ras_n    <= !((nxt == ST_COL) || (nxt == ST_CAS_HOLD) ||
                         (nxt == ST_PAGE_OPEN) || (nxt == ST_ACT && st == ST_ACT));
      dram_cas_n    <= !(nxt == ST_CAS_HOLD);
      dram_we_n     <= !(col_active && we_eff);
      dram_oe_n     <= !(nxt == ST_CAS_HOLD && !we_eff);
      if (nxt == ST_ACT)      dram_addr <= row_eff;
      else if (nxt == ST_COL) dram_addr <= col_eff;
    end
  end

  pdc_dq_path #(.DW(DW)) u_dq (
    .clk       (clk),
    .rst       (rst),
    .drive_nxt (drive_nxt),
    .wdata_nxt (wdata_eff),
    .capture   (done && !lat_we),
    .dq_in     (dram_dq_in),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .rdata     (rsp_rdata)
  );

  // R1: row address steady when the row strobe falls
  a_r1_row_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  // R2: column address steady when the column strobe falls
  a_r2_col_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  // R2: column strobe only inside an open row
  a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);
  // R3: an open-row hit keeps the row strobe low
  a_r3_hit_keeps_row: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAGE_OPEN && take && sp_hit) |=> !dram_ras_n);
  // R6: early write, write-enable already low before the column strobe falls
  a_r6_early_we: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> (!$past(dram_we_n) && $past(dram_dq_oe)));
  // R7: response is a single-cycle pulse
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R8: device output and controller drivers never overlap
  a_r8_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dram_dq_oe && !dram_oe_n));
  // R8: a gap cycle separates a read window from driving the bus
  a_r8_turn_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_dq_oe) |-> $past(dram_oe_n));
  // R9: granted pins carry inactive strobes and no request is taken
  a_r9_grant_pins: assert property (@(posedge clk) disable iff (rst)
    refresh_grant |-> (dram_ras_n && dram_cas_n && !req_ready));
endmodule

// File: tb/test_page_dram_ctrl.sv
`timescale 1ns/1ps
module test_page_dram_ctrl;
  localparam int ROW_W = 8, COL_W = 8, DW = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, refresh_grant;
  logic [7:0] rsp_rdata;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] dram_addr, dram_dq_out, dram_dq_in;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  page_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
                   .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) i_page_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .refresh_req(refresh_req), .refresh_grant(refresh_grant),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Device model: latches row/column on strobe falls, early write, read when OE low
  logic [7:0] mem [256];
  logic       wr_flag [256];
  logic [7:0] m_row = '0, m_col = '0;
  logic       p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [7:0] p_addr = '0;
  int         ras_falls = 0;
  logic [7:0] idx;

  assign idx        = {m_row[3:0], m_col[3:0]};
  assign dram_dq_in = !dram_oe_n ? (wr_flag[idx] ? mem[idx] : (m_row ^ m_col)) : 8'h00;

  initial for (int i = 0; i < 256; i++) begin mem[i] = '0; wr_flag[i] = 1'b0; end

  always @(negedge clk) if (!rst) begin
    if (p_ras && !dram_ras_n) begin
      ras_falls++;
      m_row = dram_addr;
      check(dram_addr == p_addr, "R1 row setup", dram_addr, p_addr);
    end
    if (p_cas && !dram_cas_n) begin
      m_col = dram_addr;
      check(dram_addr == p_addr, "R2 col setup", dram_addr, p_addr);
      check(!dram_ras_n, "R2 cas inside ras", dram_ras_n, 0);
      if (!dram_we_n) begin
        check(!p_we && dram_dq_oe, "R6 early write", {p_we, dram_dq_oe}, 1);
        mem[{m_row[3:0], m_col[3:0]}] = dram_dq_out;
        wr_flag[{m_row[3:0], m_col[3:0]}] = 1'b1;
      end
    end
    if (dram_dq_oe && !dram_oe_n) check(1'b0, "R8 bus clash", 1, 0);
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
  end

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_rd;
    logic [3:0]  exp_lat;
  } vec_t;

  // latency: closed 6 (R4), hit 3 (R3), hit+turn 4 (R8), miss 8 (R5)
  localparam vec_t VECS [10] = '{
    '{1'b1, 16'h1205, 8'hA5, 8'h00, 4'd6},
    '{1'b1, 16'h1206, 8'h5A, 8'h00, 4'd3},
    '{1'b0, 16'h1205, 8'h00, 8'hA5, 4'd4},
    '{1'b0, 16'h1206, 8'h00, 8'h5A, 4'd3},
    '{1'b1, 16'h3400, 8'hC3, 8'h00, 4'd8},
    '{1'b0, 16'h3400, 8'h00, 8'hC3, 4'd4},
    '{1'b0, 16'h1206, 8'h00, 8'h5A, 4'd8},
    '{1'b1, 16'h12FF, 8'h77, 8'h00, 4'd4},
    '{1'b0, 16'h12FF, 8'h00, 8'h77, 4'd4},
    '{1'b0, 16'h1200, 8'h00, 8'h12, 4'd3}
  };

  task automatic do_acc(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                        input logic [7:0] exp_rd, input int exp_lat, input string tag);
    int lat = 0;
    int falls0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    falls0 = ras_falls;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    if (!we) check(rsp_rdata == exp_rd, {tag, " read data R7"}, rsp_rdata, exp_rd);
    if (exp_lat < 5) check(ras_falls == falls0, "R3 no row strobe on hit", ras_falls, falls0);
    @(negedge clk);
    check(!rsp_valid, "R7 single pulse", rsp_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R10 strobes idle",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rsp_valid && !refresh_grant, "R10 outputs low",
          {dram_dq_oe, rsp_valid, refresh_grant}, 0);
    rst = 1'b0;

    foreach (VECS[i])
      do_acc(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].exp_rd,
             int'(VECS[i].exp_lat), $sformatf("vec%0d R3/R4/R5/R8", i));

    // R11: split of the last access (row 0x12, column 0x00)
    check(m_row == 8'h12, "R11 row pins", m_row, 8'h12);
    check(m_col == 8'h00, "R11 col pins", m_col, 8'h00);

    // R9: refresh with a row open
    @(negedge clk);
    refresh_req = 1'b1;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    while (!refresh_grant && n < 50) begin @(negedge clk); n++; end
    check(n == T_RP, "R9 grant after precharge", n, T_RP);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h1205;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!req_ready && dram_ras_n && dram_cas_n && !rsp_valid, "R9 pins held off",
            {req_ready, dram_ras_n, dram_cas_n, rsp_valid}, 4'b0110);
    end
    req_valid = 1'b0;
    refresh_req = 1'b0;
    // R9/R4: the row was closed, so this access pays a full activation
    do_acc(1'b0, 16'h1205, 8'h00, 8'hA5, T_RCD + T_CAS + 2, "R9 after refresh R4");

    // R10: reset in the middle of an open row returns strobes to idle
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dram_ras_n && !dram_dq_oe, "R10 reset closes row", {dram_ras_n, dram_dq_oe}, 2'b10);
    rst = 1'b0;
    do_acc(1'b1, 16'h0A0B, 8'h3C, 8'h00, T_RCD + T_CAS + 2, "R4 after reset");
    do_acc(1'b0, 16'h0A0B, 8'h00, 8'h3C, T_CAS + 2, "R8 turn read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule